// File: doc/BRIEF.md
# Serial Bit-Imbalance Latching Detector

This block watches a serial stream of single bits, one accepted per clock when its valid strobe is high, and keeps track of whether zeros or ones have been arriving more often since the last reset. While neither value is ahead of the other by more than one, the two-bit verdict stays at 00. The first time one value gets two ahead of the other, the block latches a verdict for that value and holds it until reset.

The verdict has a Mealy form. The bit that decides the outcome shows up at the verdict port in the same cycle that bit is presented. A registered copy then keeps the verdict on the port for every later cycle. Only five internal situations need to be remembered: zeros ahead by one, level, ones ahead by one, and the two latched outcomes. A controller tracks the difference and sends decision strobes to a small datapath, which holds the verdict and drives the output.

Top module: `imbalance_latch`

## Requirements
- R1: Reset is synchronous and active-high. While rst is high no verdict is produced. In the first cycle after rst falls, with no input yet counted, verdict is 00.
- R2: While the count of zeros minus the count of ones stays between -1 and +1, verdict is 00.
- R3: When an accepted 0 bit makes the count of zeros exceed the count of ones by two, verdict is 2'b10 (bit 1 set) in that same cycle.
- R4: When an accepted 1 bit makes the count of ones exceed the count of zeros by two, verdict is 2'b01 (bit 0 set) in that same cycle.
- R5: Once a verdict is non-zero, it stays unchanged in every later cycle until reset, whatever is presented on validIn and bitIn.
- R6: A cycle with validIn low does not count its bitIn value and does not change the tracked difference.
- R7: verdict never takes the value 2'b11.
- R8: Asserting rst after a verdict clears it. Counting then restarts from a level difference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| validIn | input | 1 | High when bitIn is to be counted this cycle |
| bitIn | input | 1 | Serial data bit |
| verdict | output | 2 | 00 undecided, 10 zeros won, 01 ones won |

## Verification
The difference tracker is the only state that leads to a decision. If it is off by one step, an early or missing verdict appears on the very bit that should, or should not, decide. At the latest, the next accepted bit exposes the error, because a level or leaning state handles that bit differently. If the latched copy is lost or corrupted, the port shows it in the cycle after the deciding bit, when the verdict no longer holds or changes value. Idle cycles with random data on bitIn, placed between accepted bits, show whether a bit that is not valid is being counted: the verdict would come one bit too early.

// File: rtl/imb_pkg.sv
`timescale 1ns/1ps
package imb_pkg;
  localparam int VERDICT_W = 2;
  localparam logic [VERDICT_W-1:0] VERDICT_NONE = 2'b00;
  localparam logic [VERDICT_W-1:0] VERDICT_ZERO = 2'b10;
  localparam logic [VERDICT_W-1:0] VERDICT_ONE  = 2'b01;

  // Difference is zeros minus ones while undecided.
  typedef enum logic [2:0] {
    ST_LEVEL     = 3'd0,
    ST_LEAN_ZERO = 3'd1,
    ST_LEAN_ONE  = 3'd2,
    ST_WON_ZERO  = 3'd3,
    ST_WON_ONE   = 3'd4
  } imbState_t;

  typedef struct packed {
    logic decideZero;
    logic decideOne;
  } ctrlStrobe_t;
endpackage

// File: rtl/imb_ctrl.sv
`timescale 1ns/1ps
module imb_ctrl
  import imb_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        validIn,
  input  logic        bitIn,
  output ctrlStrobe_t strobe
);
  imbState_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    if (validIn && !rst) begin
      unique case (stateQ)
        ST_LEVEL:     stateD = bitIn ? ST_LEAN_ONE : ST_LEAN_ZERO;
        ST_LEAN_ZERO: begin
          if (!bitIn) begin
            stateD = ST_WON_ZERO;
            strobe.decideZero = 1'b1;
          end else begin
            stateD = ST_LEVEL;
          end
        end
        ST_LEAN_ONE: begin
          if (bitIn) begin
            stateD = ST_WON_ONE;
            strobe.decideOne = 1'b1;
          end else begin
            stateD = ST_LEVEL;
          end
        end
        default: stateD = stateQ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= ST_LEVEL;
    else     stateQ <= stateD;
  end
endmodule

// File: rtl/imb_datapath.sv
`timescale 1ns/1ps
module imb_datapath
  import imb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  ctrlStrobe_t          strobe,
  output logic [VERDICT_W-1:0] verdict
);
  logic [VERDICT_W-1:0] latchQ;

  always_ff @(posedge clk) begin
    if (rst)                   latchQ <= VERDICT_NONE;
    else if (strobe.decideZero) latchQ <= VERDICT_ZERO;
    else if (strobe.decideOne)  latchQ <= VERDICT_ONE;
  end

  always_comb begin
    if (latchQ != VERDICT_NONE)  verdict = latchQ;
    else if (strobe.decideZero)  verdict = VERDICT_ZERO;
    else if (strobe.decideOne)   verdict = VERDICT_ONE;
    else                         verdict = VERDICT_NONE;
  end
endmodule

// File: rtl/imbalance_latch.sv
`timescale 1ns/1ps
module imbalance_latch
  import imb_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       validIn,
  input  logic       bitIn,
  output logic [1:0] verdict
);
  ctrlStrobe_t ctrlStrobe;

  imb_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .validIn(validIn),
    .bitIn  (bitIn),
    .strobe (ctrlStrobe)
  );

  imb_datapath u_dp (
    .clk    (clk),
    .rst    (rst),
    .strobe (ctrlStrobe),
    .verdict(verdict)
  );
endmodule

// File: rtl/imb_checker.sv
`timescale 1ns/1ps
module imb_checker (
  input logic       clk,
  input logic       rst,
  input logic       validIn,
  input logic       bitIn,
  input logic [1:0] verdict
);
  a_r1_reset_clear: assert property (@(posedge clk) rst |=> (verdict == 2'b00));

  a_r7_no_both: assert property (@(posedge clk) disable iff (rst) verdict != 2'b11);

  a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
    (verdict != 2'b00) |=> (verdict == $past(verdict)));

  a_r6_needs_valid: assert property (@(posedge clk) disable iff (rst)
    ((verdict != 2'b00) && ($past(verdict) == 2'b00) && !$past(rst)) |-> validIn);

  a_r3_zero_decides: assert property (@(posedge clk) disable iff (rst)
    ((verdict == 2'b10) && ($past(verdict) == 2'b00) && !$past(rst)) |-> !bitIn);

  a_r4_one_decides: assert property (@(posedge clk) disable iff (rst)
    ((verdict == 2'b01) && ($past(verdict) == 2'b00) && !$past(rst)) |-> bitIn);
endmodule

bind imbalance_latch imb_checker u_chk (
  .clk    (clk),
  .rst    (rst),
  .validIn(validIn),
  .bitIn  (bitIn),
  .verdict(verdict)
);

// File: tb/tb_imbalance_latch.sv
`timescale 1ns/1ps
module tb_imbalance_latch;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       validIn = 1'b0;
  logic       bitIn = 1'b0;
  logic [1:0] verdict;

  int total = 0;
  int bad = 0;
  int modelDiff = 0;        // zeros minus ones
  logic [1:0] modelLatch = 2'b00;
  bit finished = 0;

  always #10 clk = ~clk;

  imbalance_latch dut (
    .clk(clk), .rst(rst), .validIn(validIn), .bitIn(bitIn), .verdict(verdict)
  );

  task automatic step(input logic v, input logic b, input logic r, input string req);
    logic [1:0] expV;
    int nd;
    @(negedge clk);
    rst = r; validIn = v; bitIn = b;
    #5;
    nd = modelDiff;
    expV = 2'b00;
    if (modelLatch != 2'b00) expV = modelLatch;
    else if (!r && v) begin
      nd = modelDiff + (b ? -1 : 1);
      if (nd >= 2) expV = 2'b10;
      else if (nd <= -2) expV = 2'b01;
    end
    total++;
    if (verdict !== expV || verdict === 2'b11) begin
      bad++;
      $display("FAIL %s: verdict=%b expected=%b", req, verdict, expV);
    end
    if (r) begin
      modelDiff = 0; modelLatch = 2'b00;
    end else if (modelLatch == 2'b00 && v) begin
      modelDiff = nd;
      if (expV != 2'b00) modelLatch = expV;
    end
  endtask

  task automatic doReset(input string req);
    step(1'b0, 1'b0, 1'b1, req);
    step(1'b0, 1'b0, 1'b0, req);
  endtask

  initial begin
    rst = 1'b1;
    repeat (2) @(posedge clk);
    doReset("R1");
    // R3: pattern 00
    step(1, 0, 0, "R2"); step(1, 0, 0, "R3");
    // R5: stays after decision with any input
    step(1, 1, 0, "R5"); step(1, 1, 0, "R5"); step(1, 1, 0, "R5"); step(0, 1, 0, "R5");
    // R8: reset clears verdict, recount
    doReset("R8");
    step(1, 1, 0, "R8"); step(1, 1, 0, "R4");
    step(1, 0, 0, "R5"); step(1, 0, 0, "R5"); step(1, 0, 0, "R5");
    doReset("R1");
    // R2: alternating 0101...
    for (int i = 0; i < 12; i++) step(1, logic'(i % 2), 0, "R2");
    doReset("R1");
    // R2: 0110 then 1001
    step(1, 0, 0, "R2"); step(1, 1, 0, "R2"); step(1, 1, 0, "R2"); step(1, 0, 0, "R2");
    step(1, 1, 0, "R2"); step(1, 0, 0, "R2"); step(1, 0, 0, "R2"); step(1, 1, 0, "R2");
    // R6: idle cycles with ones present are not counted
    step(1, 0, 0, "R2");
    step(0, 0, 0, "R6"); step(0, 0, 0, "R6"); step(0, 1, 0, "R6");
    step(1, 0, 0, "R3");
    doReset("R1");
    step(1, 1, 0, "R2");
    step(0, 1, 0, "R6"); step(0, 1, 0, "R6");
    step(1, 0, 0, "R2"); step(1, 1, 0, "R2"); step(1, 1, 0, "R4");
    // R7: random streams with occasional resets
    for (int i = 0; i < 3000; i++) begin
      logic rr;
      rr = ($urandom % 40) == 0;
      step(logic'($urandom % 4 != 0), logic'($urandom % 2), rr, "R7");
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog: verdict=%b expected=completion", verdict);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule